// File: doc/BRIEF.md
# Descriptor-Driven Audio Playback DMA

This block is a playback DMA engine that streams 32-bit stereo samples from memory to an audio sample sink. Software places a table of two-word descriptors in memory. Each descriptor names a sample buffer, gives its length in bytes, and carries two flags: one that raises an interrupt when the buffer finishes, and one that marks the end of the table. Software loads the table address while the engine is off and then sets the enable input. The engine fetches each descriptor and reads the samples of its buffer one at a time. It hands each sample to the sink through a valid/ready handshake.

The pause input freezes the engine on the sample it is handling. The position is kept, so playback later continues from that exact sample. Dropping enable stops the engine and discards its position inside the buffer. The next enable starts again from whatever descriptor the table pointer selects at that time. The pointer moves forward as each descriptor is taken. After the end-of-table descriptor it returns to the address software last wrote, which lets a set of buffers loop without software action. A pending-interrupt flag records finished buffers. A second flag reports that a buffer finished while the previous interrupt was still unread, which tells the service routine to refill two buffers instead of one.

Top module: `audio_desc_dma`

## Requirements
- R1: A descriptor is read as two words. The engine reads the word at the table pointer first, which is the buffer base address. It then reads the word at pointer+4, whose bits 15:0 give the byte count, bit 30 is the end-of-table flag and bit 31 is the interrupt-on-completion flag.
- R2: Samples are read one word at a time from consecutive addresses, starting at the buffer base. There is one sample per 4 bytes of the count. Samples leave on `smp_data` in address order, one per cycle in which `smp_valid` and `smp_ready` are both high. `smp_data` stays constant while a sample waits for `smp_ready`.
- R3: Once the second word of a descriptor has been read, the table pointer moves forward by 8. If the end-of-table flag of that descriptor is set, the pointer instead returns to the address written last by software.
- R4: While `ctl_enable` and `ctl_pause` are both high, `mem_req` and `smp_valid` stay low. When pause clears, transfer continues at the same sample, with no sample lost or repeated.
- R5: When `ctl_enable` is low, the engine is idle, with `mem_req` and `smp_valid` low, and the table pointer keeps its value. When enable rises again, the first memory request reads the descriptor at the current table pointer. Playback then starts at the beginning of that descriptor's buffer.
- R6: A `tbl_wr` pulse loads the table pointer and the loop-back address from `tbl_wdata`, but only while `ctl_enable` is low. While enable is high the write has no effect.
- R7: After the last sample of a buffer whose interrupt flag is set has been accepted, `irq` goes high and stays high until it is cleared.
- R8: If a buffer with its interrupt flag set finishes while `irq` is already high, `err_missed` is set.
- R9: An `irq_rd` pulse clears `irq` and `err_missed`. A completion in the same cycle leaves `irq` set and `err_missed` clear.
- R10: After reset, `irq`, `err_missed`, `mem_req` and `smp_valid` are low, and the table pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Run control; low stops the engine and discards its position |
| ctl_pause | input | 1 | Freezes the engine on the current sample |
| tbl_wr | input | 1 | Table address write strobe |
| tbl_wdata | input | AW | Table address to load |
| tbl_ptr | output | AW | Current descriptor table pointer |
| irq_rd | input | 1 | Status read strobe; clears the interrupt and error flags |
| irq | output | 1 | Buffer-completion interrupt pending |
| err_missed | output | 1 | A completion arrived while an interrupt was still pending |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the word being read |
| mem_ack | input | 1 | Read acknowledge; data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sink accepts the sample |
| smp_data | output | 32 | Stereo sample, left in 31:16, right in 15:0 |

## Verification
The checker enforces four properties on every cycle. The engine stays quiet while paused or disabled. The table pointer does not move while the engine is off and nothing is written. A stalled sample stays constant. The error flag never stands without the interrupt flag, and a status read always clears it. Only the bench scenarios can show the other behaviours. These are the exact sample order across a pause, the restart point after a disable, the loop back to the latched table address, the rejected table write while running, and how missed-interrupt detection depends on the order of buffers with interrupt flags.

// File: rtl/adm_pkg.sv
package adm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC0,
      ST_DESC1,
      ST_SREAD,
      ST_SOUT,
      ST_DONE
   } adm_state_e;

   localparam int ADM_WORD_W  = 32;
   localparam int ADM_EOT_BIT = 30;
   localparam int ADM_IOC_BIT = 31;
   localparam int ADM_DESC_BYTES = 8;
   localparam int ADM_WORD_BYTES = 4;
endpackage

// File: rtl/adm_ptr.sv
module adm_ptr #(
   parameter int AW = 32,
   parameter int STEP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          adv,
   input  logic          wrap,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr    <= '0;
         base_q <= '0;
      end else if (wr_en) begin
         ptr    <= wr_addr;
         base_q <= wr_addr;
      end else if (adv) begin
         ptr <= wrap ? base_q : ptr + STEP_V;
      end
   end
endmodule

// File: rtl/adm_irq.sv
module adm_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done_ev,
   input  logic rd_clr,
   output logic pend,
   output logic err
);
   logic pend_n, err_n;

   always_comb begin
      pend_n = pend & ~rd_clr;
      err_n  = err & ~rd_clr;
      if (done_ev) begin
         err_n  = err_n | pend_n;
         pend_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         err  <= 1'b0;
      end else begin
         pend <= pend_n;
         err  <= err_n;
      end
   end
endmodule

// File: rtl/audio_desc_dma.sv
module audio_desc_dma
   import adm_pkg::*;
#(
   parameter int AW = 32,
   parameter int CNT_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_enable,
   input  logic          ctl_pause,
   input  logic          tbl_wr,
   input  logic [AW-1:0] tbl_wdata,
   output logic [AW-1:0] tbl_ptr,
   input  logic          irq_rd,
   output logic          irq,
   output logic          err_missed,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          smp_valid,
   input  logic          smp_ready,
   output logic [31:0]   smp_data
);
   localparam int SCNT_W = CNT_W - 2;
   localparam logic [AW-1:0] WSTEP = AW'(ADM_WORD_BYTES);
   localparam logic [SCNT_W-1:0] ONE = SCNT_W'(1);

   generate
      if (AW < 8 || AW > ADM_WORD_W) begin : g_bad_aw
         $error("AW must lie between 8 and 32");
      end
      if (CNT_W < 3 || CNT_W > ADM_EOT_BIT) begin : g_bad_cnt
         $error("CNT_W must lie between 3 and 30");
      end
   endgenerate

   adm_state_e        state;
   logic [AW-1:0]     cur_addr;
   logic [SCNT_W-1:0] remain;
   logic              ioc_q;
   logic [31:0]       smp_q;
   logic              active, ack_ok, ptr_adv, done_ev;
   logic [SCNT_W-1:0] new_cnt;

   assign active  = ctl_enable & ~ctl_pause;
   assign ack_ok  = mem_req & mem_ack;
   assign new_cnt = mem_rdata[CNT_W-1:2];
   assign ptr_adv = ack_ok & (state == ST_DESC1);
   assign done_ev = active & (state == ST_DONE) & ioc_q;

   always_comb begin
      mem_req = 1'b0;
      if (active) begin
         mem_req = (state == ST_DESC0) || (state == ST_DESC1) || (state == ST_SREAD);
      end
      unique case (state)
         ST_DESC0: mem_addr = tbl_ptr;
         ST_DESC1: mem_addr = tbl_ptr + WSTEP;
         default:  mem_addr = cur_addr;
      endcase
   end

   assign smp_valid = active & (state == ST_SOUT);
   assign smp_data  = smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         remain   <= '0;
         ioc_q    <= 1'b0;
         smp_q    <= '0;
      end else if (!ctl_enable) begin
         state <= ST_IDLE;
      end else if (active) begin
         unique case (state)
            ST_IDLE: state <= ST_DESC0;
            ST_DESC0: if (ack_ok) begin
               cur_addr <= mem_rdata[AW-1:0];
               state    <= ST_DESC1;
            end
            ST_DESC1: if (ack_ok) begin
               remain <= new_cnt;
               ioc_q  <= mem_rdata[ADM_IOC_BIT];
               state  <= (new_cnt == '0) ? ST_DONE : ST_SREAD;
            end
            ST_SREAD: if (ack_ok) begin
               smp_q    <= mem_rdata;
               cur_addr <= cur_addr + WSTEP;
               state    <= ST_SOUT;
            end
            ST_SOUT: if (smp_ready) begin
               remain <= remain - ONE;
               state  <= (remain == ONE) ? ST_DONE : ST_SREAD;
            end
            ST_DONE: state <= ST_DESC0;
            default: state <= ST_IDLE;
         endcase
      end
   end

   adm_ptr #(.AW(AW), .STEP(ADM_DESC_BYTES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr & ~ctl_enable),
      .wr_addr (tbl_wdata),
      .adv     (ptr_adv),
      .wrap    (mem_rdata[ADM_EOT_BIT]),
      .ptr     (tbl_ptr)
   );

   adm_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_ev (done_ev),
      .rd_clr  (irq_rd),
      .pend    (irq),
      .err     (err_missed)
   );
endmodule

// File: rtl/adm_chk.sv
module adm_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_enable,
   input logic          ctl_pause,
   input logic          tbl_wr,
   input logic [AW-1:0] tbl_ptr,
   input logic          irq_rd,
   input logic          irq,
   input logic          err_missed,
   input logic          mem_req,
   input logic          smp_valid,
   input logic          smp_ready,
   input logic [31:0]   smp_data
);
   AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_enable && ctl_pause) |-> (!mem_req && !smp_valid)); // R4

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |-> (!mem_req && !smp_valid)); // R5

   AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_enable && !tbl_wr) |=> $stable(tbl_ptr)); // R5

   AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !smp_ready) |=> $stable(smp_data)); // R2

   AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      err_missed |-> irq); // R8

   AST_READ_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rd |=> !err_missed); // R9

   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, smp_valid})); // R2
endmodule

bind audio_desc_dma adm_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_enable (ctl_enable),
   .ctl_pause  (ctl_pause),
   .tbl_wr     (tbl_wr),
   .tbl_ptr    (tbl_ptr),
   .irq_rd     (irq_rd),
   .irq        (irq),
   .err_missed (err_missed),
   .mem_req    (mem_req),
   .smp_valid  (smp_valid),
   .smp_ready  (smp_ready),
   .smp_data   (smp_data)
);

// File: tb/audio_desc_dma_test.sv
module audio_desc_dma_test;
   localparam int CLK_P = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_enable = 1'b0;
   logic          ctl_pause = 1'b0;
   logic          tbl_wr = 1'b0;
   logic [AW-1:0] tbl_wdata = '0;
   logic [AW-1:0] tbl_ptr;
   logic          irq_rd = 1'b0;
   logic          irq, err_missed;
   logic          mem_req, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_rdata;
   logic          smp_valid;
   logic          smp_ready = 1'b0;
   logic [31:0]   smp_data;

   logic [31:0] mem [256];
   logic        cyc = 1'b0;
   int          checks = 0;
   int          errors = 0;
   int          rx = 0;
   logic [31:0] exp_q [$];

   always #(CLK_P/2) clk = ~clk;
   always_ff @(posedge clk) cyc <= ~cyc;

   assign mem_rdata = mem[mem_addr[9:2]];
   assign mem_ack   = mem_req & cyc;

   audio_desc_dma #(.AW(AW), .CNT_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_pause(ctl_pause),
      .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata), .tbl_ptr(tbl_ptr),
      .irq_rd(irq_rd), .irq(irq), .err_missed(err_missed),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push_desc(input int d);
      int b;
      int n;
      b = int'(mem[d >> 2]);
      n = int'(mem[(d >> 2) + 1][15:2]);
      for (int k = 0; k < n; k++) exp_q.push_back(mem[(b >> 2) + k]);
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rx(input int target);
      int t;
      t = 0;
      while (rx < target && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(rx >= target, "R2 progress", 32'(rx), 32'(target));
   endtask

   // Reference model: every sample accepted must be the next one the descriptors predict.
   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && ctl_enable && ctl_pause)
         chk(!smp_valid && !mem_req, "R4 paused quiet", {30'b0, smp_valid, mem_req}, 32'h0);
      if (rst_n && smp_valid && smp_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected sample", smp_data, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(smp_data == e, "R2 sample order", smp_data, e);
         end
         rx++;
      end
   end

   initial begin
      #(CLK_P * 150000);
      chk(1'b0, "watchdog", 32'h0, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int t;
      for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i << 2);
      // R1 layout: base word, then count[15:0], eot bit 30, ioc bit 31
      mem[0] = 32'h0000_0100; mem[1] = 32'h8000_000C; // 3 samples, ioc
      mem[2] = 32'h0000_0200; mem[3] = 32'h8000_0008; // 2 samples, ioc
      mem[4] = 32'h0000_0300; mem[5] = 32'h4000_0010; // 4 samples, eot

      cycles(3);
      // R10 reset state
      chk(!irq, "R10 irq", {31'b0, irq}, 0);
      chk(!err_missed, "R10 err", {31'b0, err_missed}, 0);
      chk(!mem_req, "R10 mem_req", {31'b0, mem_req}, 0);
      chk(!smp_valid, "R10 smp_valid", {31'b0, smp_valid}, 0);
      chk(tbl_ptr == 0, "R10 ptr", tbl_ptr, 0);
      rst_n = 1'b1;

      // R6 write accepted while disabled
      tbl_wr = 1'b1; tbl_wdata = 32'h0; @(negedge clk); tbl_wr = 1'b0;
      chk(tbl_ptr == 0, "R6 write disabled", tbl_ptr, 0);

      for (int r = 0; r < 2; r++) begin push_desc(0); push_desc(8); push_desc(16); end
      smp_ready = 1'b1;
      ctl_enable = 1'b1;
      @(negedge clk);
      #(CLK_P/4);
      chk(mem_req && mem_addr == 32'h0, "R1 first fetch at ptr", mem_addr, 32'h0);
      wait_rx(5);
      cycles(3);
      chk(irq, "R7 irq after ioc buffer", {31'b0, irq}, 1);
      chk(err_missed, "R8 second completion unread", {31'b0, err_missed}, 1);
      irq_rd = 1'b1; @(negedge clk); irq_rd = 1'b0;
      chk(!irq && !err_missed, "R9 read clears", {30'b0, irq, err_missed}, 0);

      // R4 pause mid-buffer, order checked by the model
      wait_rx(7);
      ctl_pause = 1'b1;
      cycles(10);
      chk(rx == 7, "R4 no samples while paused", 32'(rx), 7);
      ctl_pause = 1'b0;
      wait_rx(12);
      smp_ready = 1'b0;
      cycles(12);
      chk(irq && !err_missed, "R7 irq after read, no error", {30'b0, irq, err_missed}, 32'h2);
      chk(tbl_ptr == 32'h10, "R3 ptr steps by 8", tbl_ptr, 32'h10);

      // R6 write ignored while enabled
      tbl_wr = 1'b1; tbl_wdata = 32'h40; @(negedge clk); tbl_wr = 1'b0;
      cycles(2);
      chk(tbl_ptr == 32'h10, "R6 write ignored when enabled", tbl_ptr, 32'h10);

      // R5 disable mid-buffer, restart from pointer
      ctl_enable = 1'b0;
      cycles(3);
      chk(!smp_valid && !mem_req, "R5 idle when disabled", {30'b0, smp_valid, mem_req}, 0);
      chk(tbl_ptr == 32'h10, "R5 ptr kept", tbl_ptr, 32'h10);
      exp_q.delete();
      push_desc(16); push_desc(0); push_desc(8); push_desc(16);
      ctl_enable = 1'b1;
      t = 0;
      while (!mem_req && t < 50) begin @(negedge clk); t++; end
      chk(mem_req && mem_addr == 32'h10, "R5 restart fetch at ptr", mem_addr, 32'h10);
      smp_ready = 1'b1;
      wait_rx(rx + 7);

      // R3 loop back to latched address
      ctl_enable = 1'b0;
      cycles(2);
      exp_q.delete();
      tbl_wr = 1'b1; tbl_wdata = 32'h08; @(negedge clk); tbl_wr = 1'b0;
      chk(tbl_ptr == 32'h08, "R6 write loads ptr", tbl_ptr, 32'h08);
      push_desc(8); push_desc(16); push_desc(8); push_desc(16);
      ctl_enable = 1'b1;
      t = rx;
      wait_rx(t + 6);
      smp_ready = 1'b0;
      cycles(14);
      chk(tbl_ptr == 32'h10, "R3 eot returns to latched base", tbl_ptr, 32'h10);
      smp_ready = 1'b1;
      wait_rx(t + 8);
      chk(irq, "R7 irq after looped buffer", {31'b0, irq}, 1);

      ctl_enable = 1'b0;
      cycles(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule